// File: doc/BRIEF.md
# DMA Channel Control Register with Secure and Privileged Access Rules

This block holds the 32-bit control word of one DMA channel and hands its decoded fields to the channel engine: enable, the three interrupt enables, direction, circular mode, the two address-increment flags, the two transfer sizes, priority, memory-to-memory mode and the three security attributes plus the privilege attribute. The bus side gives a single-cycle write strobe with data and two qualifiers, `acc_secure` and `acc_priv`. The same qualifiers shape the combinational read view `rd_data`.

Each write is filtered bit by bit before it lands. While the channel runs, the configuration is frozen and only the enable bit moves. The security bits answer only to secure accesses. The privilege bit answers only to privileged ones, and once it is set every field demands a privileged writer. A write that breaks a security or privilege rule is dropped as a whole and raises `illegal_pulse` for one cycle. When a secure write turns off the secure-channel bit, the source and destination security bits fall with it. Accesses never stall: there is no data stream and no back-pressure, so every pin is a plain level.

Top module: `dma_chan_cfg_reg`

## Requirements
- R1: After reset the stored word is zero, `rd_data` reads 0x00000000 and `illegal_pulse` is low.
- R2: Field positions are: 0 enable, 1 done-irq enable, 2 half-irq enable, 3 error-irq enable, 4 direction (1 = memory is the source), 5 circular, 6 peripheral increment, 7 memory increment, 9:8 peripheral size, 11:10 memory size, 13:12 priority (00 low to 11 very high), 14 memory-to-memory, 17 secure channel, 18 source secure, 19 destination secure, 20 privileged. Each decoded output equals its stored bit or bits.
- R3: Bits 15, 16 and 21 to 31 always read 0 and are unaffected by writes.
- R4: While the stored enable bit is 1, a write changes only bit 0; all other bits keep their value.
- R5: A write with `acc_secure`=0 leaves bits 17 to 19 unchanged. If it carries a 1 in bit 18 or 19, the whole write is dropped and `illegal_pulse` is high for exactly the cycle after the write.
- R6: With `acc_secure`=0, `rd_data` bits 18 and 19 read 0 whatever is stored.
- R7: A secure write to an unlocked register with bit 17 = 0 also clears bits 18 and 19, whatever the write carries there.
- R8: A write with `acc_priv`=0 whose bit 20 differs from the stored bit 20 is dropped entirely and raises `illegal_pulse`; a privileged write may change bit 20.
- R9: While stored bit 20 is 1, a write with `acc_priv`=0 that differs from the stored word in any of bits 0-14 or 17-20 is dropped and raises `illegal_pulse`; one that matches raises no pulse.
- R10: An unlocked write that carries 1 in both bit 14 and bit 5 stores bit 5 as 0; bit 5 alone is stored as written.
- R11: `per_width` and `mem_width` decode the size fields one-hot: 00 gives 001 (byte), 01 gives 010 (halfword), 10 gives 100 (word), and the invalid code 11 gives 000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one access per cycle |
| wr_data | input | 32 | Write data |
| acc_secure | input | 1 | Current access is secure (write and read) |
| acc_priv | input | 1 | Current access is privileged |
| rd_data | output | 32 | Read view, security bits masked for non-secure reads |
| ch_enable | output | 1 | Channel enable |
| irq_done_en | output | 1 | Transfer-complete interrupt enable |
| irq_half_en | output | 1 | Half-transfer interrupt enable |
| irq_err_en | output | 1 | Transfer-error interrupt enable |
| dir_mem_src | output | 1 | 1 = memory is the source |
| circ_mode | output | 1 | Circular mode |
| per_inc | output | 1 | Peripheral address increment |
| mem_inc | output | 1 | Memory address increment |
| per_size | output | 2 | Peripheral size code |
| mem_size | output | 2 | Memory size code |
| prio | output | 2 | Priority level |
| mem_to_mem | output | 1 | Memory-to-memory mode |
| sec_chan | output | 1 | Secure channel |
| src_sec | output | 1 | Source secure |
| dst_sec | output | 1 | Destination secure |
| priv_mode | output | 1 | Privileged channel |
| per_width | output | 3 | One-hot peripheral width |
| mem_width | output | 3 | One-hot memory width |
| illegal_pulse | output | 1 | One-cycle illegal-access flag |

## Verification
The configuration lock and the access filters can act on the same write. The bench provokes this by sending, while the channel is enabled, a privileged write that clears bit 20, changes the priority and keeps enable high. It also sends unprivileged writes to a privileged channel. Each result is judged both by directed expected words and by a behavioural reference model compared on every clock. That model checks the stored value, the masked read view and the cycle in which `illegal_pulse` rises.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;
  localparam int REG_W   = 32;
  localparam int SZ_W    = 2;

  localparam int B_EN    = 0;
  localparam int B_IDONE = 1;
  localparam int B_IHALF = 2;
  localparam int B_IERR  = 3;
  localparam int B_DIR   = 4;
  localparam int B_CIRC  = 5;
  localparam int B_PINC  = 6;
  localparam int B_MINC  = 7;
  localparam int B_PSZ   = 8;
  localparam int B_MSZ   = 10;
  localparam int B_PRIO  = 12;
  localparam int B_M2M   = 14;
  localparam int B_SEC   = 17;
  localparam int B_SSEC  = 18;
  localparam int B_DSEC  = 19;
  localparam int B_PRIV  = 20;

  // bits 1..14: ordinary configuration, frozen while enabled
  localparam logic [REG_W-1:0] CFG_MASK  = ((REG_W'(1) << (B_M2M + 1)) - 1) & ~(REG_W'(1) << B_EN);
  localparam logic [REG_W-1:0] SEC_MASK  = (REG_W'(1) << B_SEC) | (REG_W'(1) << B_SSEC) | (REG_W'(1) << B_DSEC);
  localparam logic [REG_W-1:0] DEP_MASK  = (REG_W'(1) << B_SSEC) | (REG_W'(1) << B_DSEC);
  localparam logic [REG_W-1:0] PRIV_MASK = REG_W'(1) << B_PRIV;
  localparam logic [REG_W-1:0] EN_MASK   = REG_W'(1) << B_EN;
  localparam logic [REG_W-1:0] IMPL_MASK = CFG_MASK | SEC_MASK | PRIV_MASK | EN_MASK;

  typedef enum logic [SZ_W-1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_BAD  = 2'b11
  } xfer_size_e;
endpackage

// File: rtl/cfg_access_ctl.sv
module cfg_access_ctl
  import dma_cfg_pkg::*;
(
  input  logic [REG_W-1:0] cur,
  input  logic             we,
  input  logic [REG_W-1:0] wd,
  input  logic             sec,
  input  logic             priv,
  output logic [REG_W-1:0] nxt,
  output logic             illegal
);
  logic             locked;
  logic             sec_viol;
  logic             priv_viol;
  logic [REG_W-1:0] wmask;
  logic [REG_W-1:0] merged;

  always_comb begin
    locked    = cur[B_EN];
    sec_viol  = !sec && (wd[B_SSEC] || wd[B_DSEC]);
    priv_viol = !priv && ((wd[B_PRIV] != cur[B_PRIV]) ||
                          (cur[B_PRIV] && (((wd ^ cur) & IMPL_MASK) != '0)));
    illegal   = we && (sec_viol || priv_viol);

    wmask = EN_MASK;
    if (!locked) begin
      wmask = wmask | CFG_MASK;
      if (priv) wmask = wmask | PRIV_MASK;
      if (sec)  wmask = wmask | SEC_MASK;
    end

    merged = (cur & ~wmask) | (wd & wmask);
    if (!locked && sec && !wd[B_SEC]) merged = merged & ~DEP_MASK;
    if (!locked && wd[B_M2M] && wd[B_CIRC]) merged[B_CIRC] = 1'b0;

    nxt = (we && !illegal) ? merged : cur;
  end
endmodule

// File: rtl/cfg_size_decode.sv
module cfg_size_decode
  import dma_cfg_pkg::*;
#(
  parameter int N_SIZES = 3
) (
  input  logic [SZ_W-1:0]    code,
  output logic [N_SIZES-1:0] onehot
);
  for (genvar i = 0; i < N_SIZES; i++) begin : g_bit
    assign onehot[i] = (code == SZ_W'(i));
  end
endmodule

// File: rtl/dma_chan_cfg_reg.sv
module dma_chan_cfg_reg
  import dma_cfg_pkg::*;
#(
  parameter int N_SIZES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [REG_W-1:0]   wr_data,
  input  logic               acc_secure,
  input  logic               acc_priv,
  output logic [REG_W-1:0]   rd_data,
  output logic               ch_enable,
  output logic               irq_done_en,
  output logic               irq_half_en,
  output logic               irq_err_en,
  output logic               dir_mem_src,
  output logic               circ_mode,
  output logic               per_inc,
  output logic               mem_inc,
  output logic [SZ_W-1:0]    per_size,
  output logic [SZ_W-1:0]    mem_size,
  output logic [SZ_W-1:0]    prio,
  output logic               mem_to_mem,
  output logic               sec_chan,
  output logic               src_sec,
  output logic               dst_sec,
  output logic               priv_mode,
  output logic [N_SIZES-1:0] per_width,
  output logic [N_SIZES-1:0] mem_width,
  output logic               illegal_pulse
);
  localparam int N_SZ_FIELDS = 2;

  logic [REG_W-1:0] cfg_q;
  logic [REG_W-1:0] cfg_d;
  logic             ill_d;

  cfg_access_ctl u_acc (
    .cur     (cfg_q),
    .we      (wr_en),
    .wd      (wr_data),
    .sec     (acc_secure),
    .priv    (acc_priv),
    .nxt     (cfg_d),
    .illegal (ill_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q         <= '0;
      illegal_pulse <= 1'b0;
    end else begin
      cfg_q         <= cfg_d;
      illegal_pulse <= ill_d;
    end
  end

  assign rd_data = acc_secure ? cfg_q : (cfg_q & ~DEP_MASK);

  assign ch_enable   = cfg_q[B_EN];
  assign irq_done_en = cfg_q[B_IDONE];
  assign irq_half_en = cfg_q[B_IHALF];
  assign irq_err_en  = cfg_q[B_IERR];
  assign dir_mem_src = cfg_q[B_DIR];
  assign circ_mode   = cfg_q[B_CIRC];
  assign per_inc     = cfg_q[B_PINC];
  assign mem_inc     = cfg_q[B_MINC];
  assign per_size    = cfg_q[B_PSZ +: SZ_W];
  assign mem_size    = cfg_q[B_MSZ +: SZ_W];
  assign prio        = cfg_q[B_PRIO +: SZ_W];
  assign mem_to_mem  = cfg_q[B_M2M];
  assign sec_chan    = cfg_q[B_SEC];
  assign src_sec     = cfg_q[B_SSEC];
  assign dst_sec     = cfg_q[B_DSEC];
  assign priv_mode   = cfg_q[B_PRIV];

  logic [N_SIZES-1:0] width_vec [N_SZ_FIELDS];

  for (genvar f = 0; f < N_SZ_FIELDS; f++) begin : g_sz
    localparam int POS = (f == 0) ? B_PSZ : B_MSZ;
    cfg_size_decode #(.N_SIZES(N_SIZES)) u_dec (
      .code   (cfg_q[POS +: SZ_W]),
      .onehot (width_vec[f])
    );
  end

  assign per_width = width_vec[0];
  assign mem_width = width_vec[1];
endmodule

// File: rtl/dma_cfg_checker.sv
module dma_cfg_checker
  import dma_cfg_pkg::*;
#(
  parameter int N_SIZES = 3
) (
  input logic               clk,
  input logic               rst_n,
  input logic               wr_en,
  input logic               acc_secure,
  input logic               acc_priv,
  input logic [REG_W-1:0]   rd_data,
  input logic [REG_W-1:0]   cfg_q,
  input logic               illegal_pulse,
  input logic [N_SIZES-1:0] per_width,
  input logic [N_SIZES-1:0] mem_width
);
  // R4
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q[B_EN] |=> (cfg_q[REG_W-1:1] == $past(cfg_q[REG_W-1:1])));

  // R5
  drop_on_illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> $stable(cfg_q));

  // R5
  pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_pulse |-> $past(wr_en && !(acc_secure && acc_priv)));

  // R3
  resv_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data & ~IMPL_MASK) == '0);

  // R6
  ns_read_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_secure |-> (rd_data[B_DSEC:B_SSEC] == 2'b00));

  // R7
  sec_dependency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q[B_SEC] |-> (cfg_q[B_DSEC:B_SSEC] == 2'b00));

  // R8
  priv_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !acc_priv) |=> $stable(cfg_q[B_PRIV]));

  // R11
  width_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(per_width) && $onehot0(mem_width));
endmodule

bind dma_chan_cfg_reg dma_cfg_checker #(.N_SIZES(N_SIZES)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .wr_en         (wr_en),
  .acc_secure    (acc_secure),
  .acc_priv      (acc_priv),
  .rd_data       (rd_data),
  .cfg_q         (cfg_q),
  .illegal_pulse (illegal_pulse),
  .per_width     (per_width),
  .mem_width     (mem_width)
);

// File: tb/sim_dma_chan_cfg_reg.sv
`timescale 1ns/1ps
module sim_dma_chan_cfg_reg;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        acc_secure = 1'b1;
  logic        acc_priv = 1'b1;
  logic [31:0] rd_data;
  logic        ch_enable, irq_done_en, irq_half_en, irq_err_en, dir_mem_src;
  logic        circ_mode, per_inc, mem_inc, mem_to_mem, sec_chan, src_sec, dst_sec, priv_mode;
  logic [1:0]  per_size, mem_size, prio;
  logic [2:0]  per_width, mem_width;
  logic        illegal_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  dma_chan_cfg_reg u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .acc_secure(acc_secure), .acc_priv(acc_priv), .rd_data(rd_data),
    .ch_enable(ch_enable), .irq_done_en(irq_done_en), .irq_half_en(irq_half_en),
    .irq_err_en(irq_err_en), .dir_mem_src(dir_mem_src), .circ_mode(circ_mode),
    .per_inc(per_inc), .mem_inc(mem_inc), .per_size(per_size), .mem_size(mem_size),
    .prio(prio), .mem_to_mem(mem_to_mem), .sec_chan(sec_chan), .src_sec(src_sec),
    .dst_sec(dst_sec), .priv_mode(priv_mode), .per_width(per_width),
    .mem_width(mem_width), .illegal_pulse(illegal_pulse)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  function automatic bit ref_illegal(input logic [31:0] cur, input logic [31:0] d,
                                     input bit s, input bit p);
    bit bad = 0;
    if (!s && (d[18] || d[19])) bad = 1;
    if (!p && d[20] != cur[20]) bad = 1;
    if (!p && cur[20]) begin
      for (int i = 0; i < 21; i++)
        if (!(i == 15 || i == 16) && d[i] != cur[i]) bad = 1;
    end
    return bad;
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] cur, input logic [31:0] d,
                                           input bit s, input bit p);
    logic [31:0] n = cur;
    if (ref_illegal(cur, d, s, p)) return cur;
    n[0] = d[0];
    if (!cur[0]) begin
      for (int i = 1; i <= 14; i++) n[i] = d[i];
      if (d[14] && d[5]) n[5] = 1'b0;
      if (p) n[20] = d[20];
      if (s) begin
        n[17] = d[17]; n[18] = d[18]; n[19] = d[19];
        if (!d[17]) begin n[18] = 1'b0; n[19] = 1'b0; end
      end
    end
    return n;
  endfunction

  function automatic logic [2:0] ref_width(input logic [1:0] c);
    case (c)
      2'd0: return 3'b001;
      2'd1: return 3'b010;
      2'd2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  logic [31:0] m_reg;
  logic        m_ill;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg <= '0;
      m_ill <= 1'b0;
    end else begin
      m_ill <= wr_en && ref_illegal(m_reg, wr_data, acc_secure, acc_priv);
      if (wr_en) m_reg <= ref_next(m_reg, wr_data, acc_secure, acc_priv);
    end
  end

  // every-cycle comparison, away from both edges
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      logic [31:0] view;
      logic [31:0] fields;
      view = m_reg;
      if (!acc_secure) begin view[18] = 1'b0; view[19] = 1'b0; end
      chk("R6 read view", rd_data, view);
      chk("R3 reserved", rd_data & 32'hFFE1_8000, 32'h0);
      fields = {11'd0, priv_mode, dst_sec, src_sec, sec_chan, 2'b00, mem_to_mem, prio,
                mem_size, per_size, mem_inc, per_inc, circ_mode, dir_mem_src,
                irq_err_en, irq_half_en, irq_done_en, ch_enable};
      chk("R2 fields", fields, m_reg);
      chk("R11 widths", {26'd0, per_width, mem_width},
          {26'd0, ref_width(m_reg[9:8]), ref_width(m_reg[11:10])});
      chk("R5 pulse", {31'd0, illegal_pulse}, {31'd0, m_ill});
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic wr(input logic [31:0] d, input bit s, input bit p);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; acc_secure = s; acc_priv = p;
    @(negedge clk);
    wr_en = 1'b0; acc_secure = 1'b1; acc_priv = 1'b1;
    #1;
  endtask

  task automatic wr_expect(input string tag, input logic [31:0] d, input bit s, input bit p,
                           input logic [31:0] exp_word, input bit exp_pulse);
    wr(d, s, p);
    chk(tag, rd_data, exp_word);
    chk(tag, {31'd0, illegal_pulse}, {31'd0, exp_pulse});
    @(negedge clk); #1;
    chk(tag, {31'd0, illegal_pulse}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R1 reset word", rd_data, 32'h0);
    chk("R1 reset pulse", {31'd0, illegal_pulse}, 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); #1;

    // R2 / R11: mixed fields, sizes 01 and 10, priority very high
    wr_expect("R2 field write", 32'h0000_395E, 1, 1, 32'h0000_395E, 0);
    chk("R11 per halfword", {29'd0, per_width}, 32'd2);
    chk("R11 mem word", {29'd0, mem_width}, 32'd4);
    chk("R2 prio", {30'd0, prio}, 32'd3);
    // R11: invalid size code 11
    wr_expect("R11 invalid size", 32'h0000_0F00, 1, 1, 32'h0000_0F00, 0);
    chk("R11 invalid width", {26'd0, per_width, mem_width}, 32'd0);
    // R10
    wr_expect("R10 m2m with circ", 32'h0000_4020, 1, 1, 32'h0000_4000, 0);
    wr_expect("R10 circ alone", 32'h0000_0020, 1, 1, 32'h0000_0020, 0);
    // R6: secure bits set, non-secure read view
    wr_expect("R6 secure set", 32'h000E_0000, 1, 1, 32'h000E_0000, 0);
    @(negedge clk); acc_secure = 1'b0; #1;
    chk("R6 ns read", rd_data, 32'h0002_0000);
    acc_secure = 1'b1;
    // R5: non-secure 1 in bit 18 -> dropped with pulse
    wr_expect("R5 ns illegal", 32'h0004_0010, 0, 1, 32'h000E_0000, 1);
    // R5: non-secure legal write keeps security bits
    wr_expect("R5 ns ignore", 32'h0000_0010, 0, 1, 32'h000E_0010, 0);
    // R7: secure clear of bit 17 drags 18/19
    wr_expect("R7 auto clear", 32'h0008_0000, 1, 1, 32'h0000_0000, 0);
    // R8
    wr_expect("R8 unpriv set", 32'h0010_0000, 1, 0, 32'h0000_0000, 1);
    wr_expect("R8 priv set", 32'h0010_0000, 1, 1, 32'h0010_0000, 0);
    // R9
    wr_expect("R9 unpriv change", 32'h0010_0002, 1, 0, 32'h0010_0000, 1);
    wr_expect("R9 unpriv same", 32'h0010_0000, 1, 0, 32'h0010_0000, 0);
    // R4: lock while enabled
    wr_expect("R4 enable", 32'h0010_0001, 1, 1, 32'h0010_0001, 0);
    wr_expect("R4 locked cfg", 32'h0000_3001, 1, 1, 32'h0010_0001, 0);
    wr_expect("R4 disable only", 32'h0000_3000, 1, 1, 32'h0010_0000, 0);
    wr_expect("R4 unlocked cfg", 32'h0000_3000, 1, 1, 32'h0000_3000, 0);
    // R3: reserved bits ignored
    wr_expect("R3 reserved write", 32'hFFE1_8000, 1, 1, 32'h0000_0000, 0);

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule